// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point result held in an unpacked form and packs it into a 32-bit IEEE-754 single-precision word. The unpacked form is a sign, a class code, an unbiased signed exponent, a wide mantissa whose top bit is the hidden 1, and a sticky bit that stands for nonzero bits already dropped upstream. The packing applies the rounding mode that travels with each item. It produces inexact, underflow and overflow flags next to the word.

Items arrive on a valid/ready stream and leave on a second valid/ready stream through a single output register. A new item is taken whenever the output register is empty or is being drained in the same cycle. A stalled output keeps its word and flags frozen until it is consumed. The rounding mode and the underflow-trap-enable bit are sampled together with the item, so consecutive items may use different modes.

Top module: `sp_result_packer`

## Requirements
- R1: An input transfer happens when `in_valid` and `in_ready` are both high. `in_ready` is high whenever `out_valid` is low or `out_ready` is high. The result of an accepted item is presented with `out_valid` high one cycle after acceptance. While `out_valid` is high and `out_ready` is low, the word and flags do not change. Results leave in acceptance order.
- R2: Class code 0 (zero) yields the sign in bit 31 with all other bits 0, and no flags.
- R3: Class code 2 (infinity) yields the sign, exponent field 255 in bits 30:23 and a zero fraction in bits 22:0, and no flags.
- R4: Class code 3 (NaN) yields exponent field 255. Fraction bits 21:0 are copied from the 22 mantissa bits just below the two top mantissa bits, and fraction bit 22 is always 1. No flags are raised.
- R5: For class code 1 (number), the exponent field is the unbiased exponent plus 127. The 23 mantissa bits below the hidden bit form the fraction, and the next bits act as guard, round and sticky. Mode 0 rounds to nearest, mode 1 toward zero, mode 2 toward plus infinity and mode 3 toward minus infinity. Inexact is raised exactly when any discarded bit or the sticky input is nonzero.
- R6: In mode 0, a discarded part of exactly one half rounds so that the fraction LSB ends up 0.
- R7: When rounding a normal carries the significand to 2.0, the exponent field goes up by one and the fraction is zero.
- R8: When the biased exponent is 0 or less, the significand, hidden bit included, is shifted right by one minus the biased exponent, with every bit shifted out joining the sticky bit, and is then rounded. The exponent field is 0. Underflow is raised when the result is inexact or when `uf_trap_en` is high.
- R9: A subnormal that rounds up into the hidden-bit position gives exponent field 1 with a zero fraction. Underflow stays clear in that case.
- R10: A biased exponent of 255 or more after rounding is an overflow. It gives the signed infinity with the overflow flag set in mode 0, in mode 2 for a positive sign, and in mode 3 for a negative sign.
- R11: An overflow in mode 1, in mode 2 with a negative sign, or in mode 3 with a positive sign gives the sign, exponent field 254 and an all-ones fraction, with the overflow flag clear.
- R12: An exact normal result raises none of the three flags. Underflow and overflow are never raised together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input item valid |
| in_ready | output | 1 | Block can take an item this cycle |
| in_sign | input | 1 | Sign of the unpacked value |
| in_class | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| in_exp | input | EXP_W | Unbiased signed exponent |
| in_mant | input | MANT_W | Significand, hidden 1 in the top bit |
| in_sticky | input | 1 | Nonzero bits already discarded upstream |
| rnd_mode | input | 2 | 0 nearest-even, 1 to zero, 2 to +inf, 3 to -inf |
| uf_trap_en | input | 1 | Underflow trap enabled |
| out_valid | output | 1 | Packed result valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_word | output | 32 | Packed single-precision word |
| out_inexact | output | 1 | Rounding discarded nonzero bits |
| out_underflow | output | 1 | Tiny result flagged as underflow |
| out_overflow | output | 1 | Result overflowed to infinity |

## Verification
The properties assume the consumer sees only what the output register holds. They also assume that items of class number carry a normalised significand with the top bit set, since NaN quietness and the flag relations are only meaningful for such items. The stimulus keeps to this: every number item has its top mantissa bit set, class and mode stay inside their 2-bit codes, and the exponents are chosen well inside the signed range of `in_exp`. Back-pressure comes from a repeating `out_ready` pattern plus one long stall, which exercises the hold and ordering rules without ever presenting an item outside these assumptions.

// File: rtl/sp_pack_pkg.sv
package sp_pack_pkg;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_NUM  = 2'd1,
    CLS_INF  = 2'd2,
    CLS_NAN  = 2'd3
  } num_class_e;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'd0,
    RND_ZERO    = 2'd1,
    RND_UP      = 2'd2,
    RND_DOWN    = 2'd3
  } rnd_mode_e;

  localparam int FRAC_W   = 23;
  localparam int EXPF_W   = 8;
  localparam int SIG_W    = FRAC_W + 1;
  localparam int BIAS     = 127;
  localparam int EXPF_TOP = 255;

  typedef struct packed {
    logic [31:0] word;
    logic        inexact;
    logic        underflow;
    logic        overflow;
  } pack_res_t;

endpackage

// File: rtl/sp_round_decide.sv
module sp_round_decide
  import sp_pack_pkg::*;
(
  input  logic      sign,
  input  rnd_mode_e mode,
  input  logic      lsb,
  input  logic      guard,
  input  logic      rnd,
  input  logic      sticky,
  output logic      inc,
  output logic      inexact
);

  always_comb begin
    inexact = guard | rnd | sticky;
    unique case (mode)
      RND_NEAREST: inc = guard & (rnd | sticky | lsb);
      RND_ZERO:    inc = 1'b0;
      RND_UP:      inc = inexact & ~sign;
      default:     inc = inexact & sign;
    endcase
  end

endmodule

// File: rtl/sp_ovf_select.sv
module sp_ovf_select
  import sp_pack_pkg::*;
(
  input  logic      sign,
  input  rnd_mode_e mode,
  output logic      to_inf
);

  always_comb begin
    unique case (mode)
      RND_NEAREST: to_inf = 1'b1;
      RND_ZERO:    to_inf = 1'b0;
      RND_UP:      to_inf = ~sign;
      default:     to_inf = sign;
    endcase
  end

endmodule

// File: rtl/sp_align_shift.sv
module sp_align_shift #(
  parameter int MANT_W = 32,
  parameter int SH_W   = $clog2(MANT_W + 1)
) (
  input  logic [MANT_W-1:0] mant,
  input  logic [SH_W-1:0]   sh,
  output logic [MANT_W-1:0] shifted,
  output logic              lost
);

  assign shifted = mant >> sh;
  assign lost    = (shifted << sh) != mant;

endmodule

// File: rtl/sp_pack_core.sv
module sp_pack_core
  import sp_pack_pkg::*;
#(
  parameter int EXP_W  = 10,
  parameter int MANT_W = 32
) (
  input  logic                    in_sign,
  input  num_class_e              in_class,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [MANT_W-1:0]       in_mant,
  input  logic                    in_sticky,
  input  rnd_mode_e               mode,
  input  logic                    trap_en,
  output pack_res_t               res
);

  localparam int E_W   = EXP_W + 2;
  localparam int SH_W  = $clog2(MANT_W + 1);
  localparam int G_IDX = MANT_W - SIG_W - 1;
  localparam int R_IDX = G_IDX - 1;
  localparam int S_TOP = R_IDX - 1;

  logic signed [E_W-1:0] e_b;
  logic signed [E_W-1:0] sh_raw;
  logic signed [E_W-1:0] e_fin;
  logic                  is_sub;
  logic [SH_W-1:0]       sh;
  logic [MANT_W-1:0]     shifted;
  logic                  lost;
  logic [SIG_W-1:0]      keep;
  logic                  guard, rnd, stk;
  logic                  inc, inexact, to_inf;
  logic [SIG_W:0]        sum;

  assign e_b    = E_W'(in_exp) + E_W'(BIAS);
  assign is_sub = e_b[E_W-1] || (e_b == '0);
  assign sh_raw = E_W'(1) - e_b;

  always_comb begin
    if (!is_sub)
      sh = '0;
    else if (sh_raw > E_W'(MANT_W))
      sh = SH_W'(MANT_W);
    else
      sh = sh_raw[SH_W-1:0];
  end

  sp_align_shift #(.MANT_W(MANT_W), .SH_W(SH_W)) u_align (
    .mant    (in_mant),
    .sh      (sh),
    .shifted (shifted),
    .lost    (lost)
  );

  assign keep  = shifted[MANT_W-1 -: SIG_W];
  assign guard = shifted[G_IDX];
  assign rnd   = shifted[R_IDX];
  assign stk   = (|shifted[S_TOP:0]) | lost | in_sticky;

  sp_round_decide u_round (
    .sign    (in_sign),
    .mode    (mode),
    .lsb     (keep[0]),
    .guard   (guard),
    .rnd     (rnd),
    .sticky  (stk),
    .inc     (inc),
    .inexact (inexact)
  );

  sp_ovf_select u_ovf (
    .sign   (in_sign),
    .mode   (mode),
    .to_inf (to_inf)
  );

  assign sum   = {1'b0, keep} + (SIG_W+1)'(inc);
  assign e_fin = e_b + E_W'(sum[SIG_W]);

  always_comb begin
    res = '0;
    res.word[31] = in_sign;
    unique case (in_class)
      CLS_ZERO: ;
      CLS_INF:  res.word[30:23] = EXPF_W'(EXPF_TOP);
      CLS_NAN: begin
        res.word[30:23] = EXPF_W'(EXPF_TOP);
        res.word[22:0]  = {1'b1, in_mant[MANT_W-3 -: FRAC_W-1]};
      end
      default: begin
        res.inexact = inexact;
        if (is_sub) begin
          res.word[30:23] = {{(EXPF_W-1){1'b0}}, sum[SIG_W-1]};
          res.word[22:0]  = sum[FRAC_W-1:0];
          res.underflow   = ~sum[SIG_W-1] & (inexact | trap_en);
        end else if (e_fin >= E_W'(EXPF_TOP)) begin
          if (to_inf) begin
            res.word[30:23] = EXPF_W'(EXPF_TOP);
            res.overflow    = 1'b1;
          end else begin
            res.word[30:23] = EXPF_W'(EXPF_TOP - 1);
            res.word[22:0]  = '1;
          end
        end else begin
          res.word[30:23] = e_fin[EXPF_W-1:0];
          res.word[22:0]  = sum[FRAC_W-1:0];
        end
      end
    endcase
  end

endmodule

// File: rtl/sp_result_packer.sv
module sp_result_packer
  import sp_pack_pkg::*;
#(
  parameter int EXP_W  = 10,
  parameter int MANT_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_sign,
  input  logic [1:0]              in_class,
  input  logic signed [EXP_W-1:0] in_exp,
  input  logic [MANT_W-1:0]       in_mant,
  input  logic                    in_sticky,
  input  logic [1:0]              rnd_mode,
  input  logic                    uf_trap_en,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [31:0]             out_word,
  output logic                    out_inexact,
  output logic                    out_underflow,
  output logic                    out_overflow
);

  pack_res_t res_d;
  pack_res_t res_q;
  logic      take;

  sp_pack_core #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_core (
    .in_sign   (in_sign),
    .in_class  (num_class_e'(in_class)),
    .in_exp    (in_exp),
    .in_mant   (in_mant),
    .in_sticky (in_sticky),
    .mode      (rnd_mode_e'(rnd_mode)),
    .trap_en   (uf_trap_en),
    .res       (res_d)
  );

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_q     <= '0;
    end else begin
      if (take)
        res_q <= res_d;
      if (in_ready)
        out_valid <= in_valid;
    end
  end

  assign out_word      = res_q.word;
  assign out_inexact   = res_q.inexact;
  assign out_underflow = res_q.underflow;
  assign out_overflow  = res_q.overflow;

endmodule

// File: rtl/sp_result_packer_chk.sv
module sp_result_packer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_word,
  input logic        out_inexact,
  input logic        out_underflow,
  input logic        out_overflow
);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_word)
      && $stable(out_inexact) && $stable(out_underflow) && $stable(out_overflow));

  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_nan_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_word[30:23] == 8'hFF && out_word[22:0] != 23'd0 |-> out_word[22]);

  p_ovf_inf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_overflow |-> out_word[30:0] == {8'hFF, 23'd0});

  p_uf_subexp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_underflow |-> out_word[30:23] == 8'd0);

  p_flag_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_underflow && out_overflow));

endmodule

bind sp_result_packer sp_result_packer_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_ready      (in_ready),
  .out_valid     (out_valid),
  .out_ready     (out_ready),
  .out_word      (out_word),
  .out_inexact   (out_inexact),
  .out_underflow (out_underflow),
  .out_overflow  (out_overflow)
);

// File: tb/sp_result_packer_bench.sv
`timescale 1ns/1ps
module sp_result_packer_bench;

  localparam int EXP_W  = 10;
  localparam int MANT_W = 32;
  localparam int LIMIT  = 20000;

  logic                    clk = 1'b0;
  logic                    rst_n = 1'b0;
  logic                    in_valid = 1'b0;
  logic                    in_ready;
  logic                    in_sign = 1'b0;
  logic [1:0]              in_class = 2'd0;
  logic signed [EXP_W-1:0] in_exp = '0;
  logic [MANT_W-1:0]       in_mant = '0;
  logic                    in_sticky = 1'b0;
  logic [1:0]              rnd_mode = 2'd0;
  logic                    uf_trap_en = 1'b0;
  logic                    out_valid;
  logic                    out_ready = 1'b1;
  logic [31:0]             out_word;
  logic                    out_inexact, out_underflow, out_overflow;

  int checks = 0;
  int errors = 0;
  int sent = 0;
  int got = 0;
  int cyc = 0;
  bit stall = 1'b0;

  logic [34:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  sp_result_packer #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_sp_result_packer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_class(in_class), .in_exp(in_exp), .in_mant(in_mant),
    .in_sticky(in_sticky), .rnd_mode(rnd_mode), .uf_trap_en(uf_trap_en),
    .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
    .out_inexact(out_inexact), .out_underflow(out_underflow), .out_overflow(out_overflow)
  );

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Watchdog: an expired run counts as a failure.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > LIMIT) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1: actual cycles %0d expected below %0d", cyc, LIMIT);
      finish_run();
    end
  end

  // Back-pressure pattern, changed just after the edge.
  initial begin
    forever begin
      @(posedge clk);
      #1 out_ready = !stall && ((cyc % 5) != 3);
    end
  end

  // Monitor: compare each consumed result with the scoreboard.
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      logic [34:0] act;
      logic [34:0] exp_v;
      string       t;
      act = {out_word, out_inexact, out_underflow, out_overflow};
      checks++;
      got++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1: unexpected result actual %h expected none", act);
      end else begin
        exp_v = exp_q.pop_front();
        t = tag_q.pop_front();
        if (act !== exp_v) begin
          errors++;
          $display("FAIL %s: actual word %h i/u/o %b expected word %h i/u/o %b",
                   t, act[34:3], act[2:0], exp_v[34:3], exp_v[2:0]);
        end
      end
    end
  end

  // Driver: called just after a rising edge.
  task automatic send(input bit s, input int cls, input int e, input logic [31:0] m,
                      input bit stk, input int md, input bit trap,
                      input logic [31:0] w, input bit ei, input bit eu, input bit eo,
                      input string tag);
    in_sign = s; in_class = 2'(cls); in_exp = EXP_W'(e); in_mant = m;
    in_sticky = stk; rnd_mode = 2'(md); uf_trap_en = trap; in_valid = 1'b1;
    forever begin
      @(negedge clk);
      if (in_ready) begin
        exp_q.push_back({w, ei, eu, eo});
        tag_q.push_back(tag);
        sent++;
        break;
      end
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 reset: actual valid %b ready %b expected 0 1", out_valid, in_ready);
    end
    @(posedge clk); #1;

    // R2 zero, R3 infinity, R4 NaN
    send(1, 0, 0, 32'h0, 0, 0, 1, 32'h80000000, 0, 0, 0, "R2");
    send(0, 2, 0, 32'h0, 0, 0, 0, 32'h7F800000, 0, 0, 0, "R3");
    send(1, 3, 0, 32'h80123400, 0, 0, 0, 32'hFFC01234, 0, 0, 0, "R4");
    send(0, 3, 0, 32'hC0000000, 0, 0, 0, 32'h7FC00000, 0, 0, 0, "R4");
    // R5 / R12 exact and directed rounding
    send(0, 1, 0, 32'hC0000000, 0, 0, 0, 32'h3FC00000, 0, 0, 0, "R12");
    send(0, 1, 0, 32'h800001C0, 0, 0, 0, 32'h3F800002, 1, 0, 0, "R5");
    send(0, 1, 0, 32'h800001C0, 0, 1, 0, 32'h3F800001, 1, 0, 0, "R5");
    send(0, 1, 0, 32'h80000001, 0, 2, 0, 32'h3F800001, 1, 0, 0, "R5");
    send(1, 1, 0, 32'h80000001, 0, 2, 0, 32'hBF800000, 1, 0, 0, "R5");
    send(1, 1, 0, 32'h80000001, 0, 3, 0, 32'hBF800001, 1, 0, 0, "R5");
    send(0, 1, 0, 32'h80000000, 1, 3, 0, 32'h3F800000, 1, 0, 0, "R5");
    // R6 ties
    send(0, 1, 0, 32'h80000080, 0, 0, 0, 32'h3F800000, 1, 0, 0, "R6");
    send(0, 1, 0, 32'h80000180, 0, 0, 0, 32'h3F800002, 1, 0, 0, "R6");
    send(0, 1, 0, 32'h80000080, 1, 0, 0, 32'h3F800001, 1, 0, 0, "R6");
    // R7 carry into exponent
    send(0, 1, 0, 32'hFFFFFF80, 0, 0, 0, 32'h40000000, 1, 0, 0, "R7");
    // R10 / R11 overflow
    send(0, 1, 127, 32'hFFFFFFC0, 0, 0, 0, 32'h7F800000, 1, 0, 1, "R10");
    send(1, 1, 128, 32'h80000000, 0, 0, 0, 32'hFF800000, 0, 0, 1, "R10");
    send(0, 1, 200, 32'h80000000, 0, 2, 0, 32'h7F800000, 0, 0, 1, "R10");
    send(1, 1, 200, 32'h80000000, 0, 3, 0, 32'hFF800000, 0, 0, 1, "R10");
    send(0, 1, 128, 32'h80000000, 0, 1, 0, 32'h7F7FFFFF, 0, 0, 0, "R11");
    send(1, 1, 200, 32'h80000000, 0, 2, 0, 32'hFF7FFFFF, 0, 0, 0, "R11");
    send(0, 1, 200, 32'h80000000, 0, 3, 0, 32'h7F7FFFFF, 0, 0, 0, "R11");
    // R8 subnormals
    send(0, 1, -127, 32'h80000000, 0, 0, 0, 32'h00400000, 0, 0, 0, "R8");
    send(0, 1, -127, 32'h80000000, 0, 0, 1, 32'h00400000, 0, 1, 0, "R8");
    send(0, 1, -130, 32'h80000010, 0, 0, 0, 32'h00080000, 1, 1, 0, "R8");
    send(0, 1, -300, 32'h80000000, 0, 2, 0, 32'h00000001, 1, 1, 0, "R8");
    send(1, 1, -300, 32'h80000000, 0, 0, 0, 32'h80000000, 1, 1, 0, "R8");
    // R9 subnormal rounding to smallest normal
    send(0, 1, -127, 32'hFFFFFF00, 0, 0, 1, 32'h00800000, 1, 0, 0, "R9");

    // R1 long stall: queue one item, hold it, then release.
    stall = 1'b1;
    send(0, 1, 0, 32'hC0000000, 0, 0, 0, 32'h3FC00000, 0, 0, 0, "R1");
    repeat (6) @(posedge clk);
    #1;
    checks++;
    if (out_valid !== 1'b1 || out_word !== 32'h3FC00000) begin
      errors++;
      $display("FAIL R1 hold: actual valid %b word %h expected 1 3fc00000", out_valid, out_word);
    end
    stall = 1'b0;
    send(1, 2, 0, 32'h0, 0, 0, 0, 32'hFF800000, 0, 0, 0, "R1");

    repeat (20) @(posedge clk);
    @(negedge clk);
    checks++;
    if (got != sent || exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 count: actual %0d expected %0d", got, sent);
    end
    finish_run();
  end

endmodule